// File: doc/BRIEF.md
# Byte-Addressed Load/Store Access Unit

This unit sits between a simple processor core and a 32-bit data memory that is addressed in bytes. For each command it adds the base register value to a sign-extended 16-bit displacement to form the effective address. It then checks that the address suits the access size (byte, half-word or word). For accepted accesses it drives per-byte lane enables and steers store data into little-endian lanes. On loads it picks the addressed bytes out of the returned word and extends them to 32 bits.

A misaligned half-word or word access is trapped. The memory never sees it, a one-cycle error pulse is raised, and the faulting effective address is latched on an output for the exception logic. Legal accesses go out on a valid/ready handshake and end with a one-cycle done strobe.

The control is a four-state machine. `ST_IDLE` waits for a command. `ST_WAIT` holds the memory request until ready is seen. `ST_RESP` gives the done pulse. `ST_TRAP` gives the misalignment pulse. The transitions are:
- IDLE→WAIT on an aligned command.
- IDLE→TRAP on a misaligned command.
- WAIT→WAIT while ready is low.
- WAIT→RESP when ready is seen.
- RESP→IDLE and TRAP→IDLE unconditionally.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is `base + sign_extend(disp)`. A displacement of 0x8000 subtracts 0x8000 from the base, and a zero displacement gives exactly the base. It appears on `mem_addr` as a full byte address.
- R2: `cmd_size` encodes 2'b00 = byte, 2'b01 = half-word, 2'b10 = word. The code 2'b11 behaves as word.
- R3: A half-word whose address has bit 0 set, or a word whose address bits [1:0] are non-zero, is misaligned. It never raises `mem_valid`. `misalign_err` is high for exactly the one cycle after acceptance. `fault_addr` takes the effective address in that cycle and holds it until the next misaligned command.
- R4: `mem_be` bit i enables byte lane i (bits [8i+7:8i]). A byte access enables lane addr[1:0]. A half-word enables lanes 0 and 1 (4'b0011) when addr[1]=0, or lanes 2 and 3 (4'b1100) when addr[1]=1. A word enables 4'b1111.
- R5: Store data is little-endian. A word goes out unchanged. A half-word is replicated into both halves, and a byte into all four lanes.
- R6: With `cmd_signed` low, a load returns the byte at lane addr[1:0], or the half-word at lanes {addr[1],0}/{addr[1],1} (low byte first), zero-extended to 32 bits. A word load returns `mem_rdata` unchanged.
- R7: With `cmd_signed` high, byte and half-word loads are sign-extended from their top bit instead.
- R8: An accepted aligned command raises `mem_valid` in the next cycle. `mem_addr`, `mem_be`, `mem_wdata` and `mem_write` stay stable until a clock edge samples `mem_ready` high, and `mem_valid` drops in the following cycle.
- R9: `done` is high for exactly one cycle, the cycle after the edge that samples `mem_ready` high, for both loads and stores. `rdata` is updated in that cycle on loads only and otherwise holds its value.
- R10: `busy` is high from the cycle after acceptance through the done or error cycle. A `cmd_valid` seen while busy is ignored.
- R11: After reset, `busy`, `done`, `misalign_err`, `mem_valid`, `rdata` and `fault_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_size | input | 2 | Access size code |
| cmd_signed | input | 1 | Sign-extend load result |
| cmd_base | input | 32 | Base register value |
| cmd_disp | input | 16 | Signed displacement |
| cmd_wdata | input | 32 | Store value, right-justified |
| busy | output | 1 | Command in progress |
| done | output | 1 | Access completed strobe |
| rdata | output | 32 | Aligned, extended load result |
| misalign_err | output | 1 | Misalignment pulse |
| fault_addr | output | 32 | Last misaligned effective address |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address to memory |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_rdata | input | 32 | Memory read word |

## Verification
Stores and loads are driven at every lane offset for each size. Returned words with the top bit of the selected byte or half-word both set and clear separate zero extension from sign extension, and show that the wrong lane was chosen. The tests use positive, negative, zero and 0x8000 displacements, with carries across the upper half of the base, which shows whether the displacement is sign-extended and added at full width. Misaligned half-word and word addresses, mixed with legal ones and with memory stalls of several lengths, check that the trap is taken, that the request stays stable, and that commands arriving during a stall are ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2,
        ST_TRAP = 2'd3
    } lsu_state_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned,
    output logic [LANES-1:0]  lane_en
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [OFF_W-1:0]  off;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        eff_addr = base + disp_ext;
        off      = eff_addr[OFF_W-1:0];
        case (acc_size_e'(size))
            SZ_BYTE: begin
                misaligned = 1'b0;
                lane_en    = LANES'(1) << off;
            end
            SZ_HALF: begin
                misaligned = off[0];
                lane_en    = LANES'(3) << {off[1], 1'b0};
            end
            default: begin
                misaligned = |off;
                lane_en    = {LANES{1'b1}};
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] lanes
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: lanes = {LANES{value[7:0]}};
            SZ_HALF: lanes = {2{value[HALF_W-1:0]}};
            default: lanes = value;
        endcase
    end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
    import lsu_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              sign_ext,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] value
);
    localparam int HALF_W = DATA_W / 2;

    logic [7:0]        byte_pick;
    logic [HALF_W-1:0] half_pick;

    always_comb begin
        byte_pick = word_in[{off, 3'b000} +: 8];
        half_pick = word_in[{off[1], 4'b0000} +: HALF_W];
        case (acc_size_e'(size))
            SZ_BYTE: value = {{(DATA_W-8){sign_ext & byte_pick[7]}}, byte_pick};
            SZ_HALF: value = {{(DATA_W-HALF_W){sign_ext & half_pick[HALF_W-1]}}, half_pick};
            default: value = word_in;
        endcase
    end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_size,
    input  logic              cmd_signed,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [DISP_W-1:0] cmd_disp,
    input  logic [31:0]       cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              misalign_err,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata
);
    lsu_state_e state_q, state_d;

    logic [ADDR_W-1:0] ea;
    logic              bad_align;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] lanes_c;
    logic [DATA_W-1:0] load_c;

    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic [1:0]        size_q;
    logic              signed_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ADDR_W-1:0] fault_q;

    logic accept;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base       (cmd_base),
        .disp       (cmd_disp),
        .size       (cmd_size),
        .eff_addr   (ea),
        .misaligned (bad_align),
        .lane_en    (be_c)
    );

    lsu_store_lanes u_st (
        .size  (cmd_size),
        .value (cmd_wdata),
        .lanes (lanes_c)
    );

    lsu_load_lanes u_ld (
        .size     (size_q),
        .sign_ext (signed_q),
        .off      (addr_q[OFF_W-1:0]),
        .word_in  (mem_rdata),
        .value    (load_c)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = bad_align ? ST_TRAP : ST_WAIT;
            ST_WAIT: if (mem_ready) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            ST_TRAP: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            size_q   <= '0;
            signed_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= ea;
            be_q     <= be_c;
            wdata_q  <= lanes_c;
            write_q  <= cmd_write;
            size_q   <= cmd_size;
            signed_q <= cmd_signed;
        end
    end

    // load result and fault address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            fault_q <= '0;
        end else begin
            if (state_q == ST_WAIT && mem_ready && !write_q) rdata_q <= load_c;
            if (accept && bad_align) fault_q <= ea;
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_valid    = 1'b0;
        done         = 1'b0;
        misalign_err = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: busy         = 1'b0;
            ST_WAIT: mem_valid    = 1'b1;
            ST_RESP: done         = 1'b1;
            ST_TRAP: misalign_err = 1'b1;
        endcase
    end

    assign mem_write  = write_q;
    assign mem_addr   = addr_q;
    assign mem_be     = be_q;
    assign mem_wdata  = wdata_q;
    assign rdata      = rdata_q;
    assign fault_addr = fault_q;
endmodule

// File: rtl/lsu_unit_checker.sv
module lsu_unit_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              misalign_err,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready
);
    assert_trap_no_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> !mem_valid && !done);

    assert_err_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |=> !misalign_err);

    assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                       mem_be == 4'b1100 || mem_be == 4'b1111));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_be) && $stable(mem_wdata) && $stable(mem_write));

    assert_release_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid && done);

    assert_done_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_busy_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || done || misalign_err) |-> busy);
endmodule

bind lsu_unit lsu_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .misalign_err (misalign_err),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready)
);

// File: tb/sim_lsu_unit.sv
module sim_lsu_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_signed = 1'b0;
    logic [1:0]  cmd_size = 2'b00;
    logic [31:0] cmd_base = '0, cmd_wdata = '0;
    logic [15:0] cmd_disp = '0;
    logic        busy, done, misalign_err, mem_valid, mem_write;
    logic [31:0] rdata, fault_addr, mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [31:0] last_rdata = '0;
    logic [31:0] last_fault = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_size(cmd_size), .cmd_signed(cmd_signed), .cmd_base(cmd_base),
        .cmd_disp(cmd_disp), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rdata(rdata), .misalign_err(misalign_err), .fault_addr(fault_addr),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 50000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // reference model: one full command, compared every cycle at the falling edge
    task automatic run_op(input bit wr, input logic [1:0] sz, input bit sg,
                          input logic [31:0] base, input logic [15:0] disp,
                          input logic [31:0] wd, input logic [31:0] word, input int stall);
        logic [31:0] ea, exp_wd, exp_rd;
        logic [3:0]  exp_be;
        logic [7:0]  b;
        logic [15:0] h;
        bit          bad;
        ea = base + {{16{disp[15]}}, disp};
        case (sz)
            2'b00: begin bad = 0; exp_be = 4'b0001 << ea[1:0]; exp_wd = {4{wd[7:0]}}; end
            2'b01: begin bad = ea[0]; exp_be = ea[1] ? 4'b1100 : 4'b0011; exp_wd = {2{wd[15:0]}}; end
            default: begin bad = (ea[1:0] != 0); exp_be = 4'b1111; exp_wd = wd; end
        endcase
        b = word[8*ea[1:0] +: 8];
        h = ea[1] ? word[31:16] : word[15:0];
        case (sz)
            2'b00:   exp_rd = sg ? {{24{b[7]}}, b} : {24'd0, b};
            2'b01:   exp_rd = sg ? {{16{h[15]}}, h} : {16'd0, h};
            default: exp_rd = word;
        endcase

        @(negedge clk);
        cmd_valid = 1; cmd_write = wr; cmd_size = sz; cmd_signed = sg;
        cmd_base = base; cmd_disp = disp; cmd_wdata = wd;
        @(negedge clk);
        if (bad) begin
            cmd_valid = 0;
            chk(misalign_err == 1, "R3 err pulse", 32'(misalign_err), 1);
            chk(mem_valid == 0, "R3 no request", 32'(mem_valid), 0);
            chk(fault_addr == ea, "R3 fault addr", fault_addr, ea);
            chk(busy == 1, "R10 busy on trap", 32'(busy), 1);
            last_fault = ea;
            @(negedge clk);
            chk(misalign_err == 0, "R3 err one cycle", 32'(misalign_err), 0);
            chk(busy == 0, "R10 idle after trap", 32'(busy), 0);
            chk(rdata == last_rdata, "R9 rdata kept on trap", rdata, last_rdata);
            return;
        end
        // stray commands while busy must be ignored (R10)
        cmd_base = ~base; cmd_size = 2'b00; cmd_wdata = ~wd;
        for (int d = 0; d <= stall; d++) begin
            chk(mem_valid == 1, "R8 valid held", 32'(mem_valid), 1);
            chk(mem_addr == ea, "R1 address", mem_addr, ea);
            chk(mem_be == exp_be, "R4 lane enables", 32'(mem_be), 32'(exp_be));
            chk(mem_write == wr, "R8 write flag", 32'(mem_write), 32'(wr));
            if (wr) chk(mem_wdata == exp_wd, "R5 store lanes", mem_wdata, exp_wd);
            chk(done == 0, "R9 no early done", 32'(done), 0);
            mem_ready = (d == stall);
            mem_rdata = (d == stall) ? word : ~word;
            if (d == stall) cmd_valid = 0;
            @(negedge clk);
        end
        mem_ready = 0;
        if (!wr) last_rdata = exp_rd;
        chk(done == 1, "R9 done pulse", 32'(done), 1);
        chk(mem_valid == 0, "R8 valid released", 32'(mem_valid), 0);
        chk(rdata == last_rdata, sg ? "R7 signed load" : "R6 load align", rdata, last_rdata);
        @(negedge clk);
        chk(done == 0, "R9 done one cycle", 32'(done), 0);
        chk(busy == 0, "R10 idle", 32'(busy), 0);
        chk(fault_addr == last_fault, "R3 fault addr held", fault_addr, last_fault);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && misalign_err == 0 && mem_valid == 0, "R11 reset flags",
            {busy, done, misalign_err, mem_valid}, 0);
        chk(rdata == 0 && fault_addr == 0, "R11 reset data", rdata | fault_addr, 0);
        rst_n = 1;
        // R1 zero displacement, R2 word code, R5 word store
        run_op(1, 2'b10, 0, 32'h0020_0000, 16'h0000, 32'h1122_3344, 0, 0);
        run_op(0, 2'b10, 0, 32'h0020_0000, 16'h0004, 0, 32'h1122_3344, 2);
        // R1 0x8000 subtracts; byte store lane 1
        run_op(1, 2'b00, 0, 32'h0021_8001, 16'h8000, 32'h0000_00AB, 0, 1);
        // R6/R7 byte loads at every lane
        for (int k = 0; k < 4; k++) begin
            run_op(0, 2'b00, 0, 32'h1000_0000, 16'(k), 0, 32'h80FF_7F01, k);
            run_op(0, 2'b00, 1, 32'h1000_0000, 16'(k), 0, 32'h80FF_7F01, 0);
        end
        // half-words both positions, both extensions, negative displacement
        run_op(0, 2'b01, 0, 32'h0000_1006, 16'hFFFC, 0, 32'h8001_1234, 0);
        run_op(0, 2'b01, 1, 32'h0000_1006, 16'hFFFC, 0, 32'h8001_1234, 3);
        run_op(0, 2'b01, 1, 32'h0000_1004, 16'h0000, 0, 32'h1234_F00D, 0);
        run_op(1, 2'b01, 0, 32'h0000_1002, 16'h0000, 32'hDEAD_5566, 0, 0);
        run_op(1, 2'b01, 0, 32'h0000_1000, 16'h0000, 32'hDEAD_7788, 0, 1);
        // R3 misaligned half-word and word, then legal traffic keeps fault address
        run_op(0, 2'b01, 0, 32'h0000_2001, 16'h0000, 0, 0, 0);
        run_op(1, 2'b10, 0, 32'h0000_2000, 16'h0002, 32'h1, 0, 0);
        run_op(0, 2'b10, 0, 32'hFFFF_FFFF, 16'h0001, 0, 32'hCAFE_BABE, 4);
        // R2 code 2'b11 behaves as word: store and misaligned trap
        run_op(1, 2'b11, 0, 32'h0000_3000, 16'h0008, 32'h0102_0304, 0, 0);
        run_op(1, 2'b11, 0, 32'h0000_3000, 16'h0003, 32'h0102_0304, 0, 0);
        // byte store at lane 3 with carry into upper half
        run_op(1, 2'b00, 0, 32'h0001_FFFF, 16'h0004, 32'h0000_005A, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule